// File: doc/BRIEF.md
# Start-Up Delay Sequencer

This block decides when a device may leave reset or stall after a power-up, a brown-out, a wake from sleep or a clock source switch. It reads which event occurred, the selected clock source and whether the power-up timer is enabled. From these it builds a short chain of waits and runs them one after another. The waits are a power-up timer, a recovery delay for clock sources that need no start-up, an oscillator start-up count and a PLL lock wait.

Every wait is a parameter given in ticks of `clk_i`. A wait that does not apply to the event and clock source is skipped in zero cycles. When the chain ends, `release_o` goes high and stays high until the next event. An event accepted while a chain is running drops whatever was in progress. The block then starts again from the first wait that the new event needs.

Top module: `start_delay_seq`

## Requirements
- R1: While `rst_ni` is low and after it rises, `release_o` is low, and it stays low until the first accepted event.
- R2: An event is accepted on a rising edge of `clk_i` where `event_valid_i` is high. `event_kind_i` encodes it: 0 power-up, 1 brown-out, 2 wake from sleep, 3 clock switch. `osc_mode_i` encodes the clock source: 0 high-speed crystal with PLL, 1 crystal without PLL, 2 external clock, 3 external RC. If an event is accepted at edge k and its total wait is T cycles, `release_o` is low from edge k and goes high at edge k+T.
- R3: Power-up waits PWRT_TICKS if `pwrt_en_i` is 1, then OST_TICKS for modes 0 and 1, then PLL_TICKS for mode 0. With the timer disabled in mode 2 or 3, the wait is zero and `release_o` is high right after the accepting edge.
- R4: Brown-out always waits PWRT_TICKS, whatever `pwrt_en_i` is. It then adds OST_TICKS for modes 0 and 1, and PLL_TICKS for mode 0.
- R5: Wake from sleep waits OST_TICKS in modes 0 and 1, plus PLL_TICKS in mode 0. In modes 2 and 3 it waits only REC_TICKS.
- R6: Clock switch waits OST_TICKS in modes 0 and 1, plus PLL_TICKS in mode 0. In modes 2 and 3 it releases with zero wait.
- R7: An event accepted while a wait is in progress discards that wait. The release time is then set only by the new event, counted from its accepting edge.
- R8: Once high, `release_o` stays high until the next accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; every wait counts its ticks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_valid_i | input | 1 | An event is presented this cycle |
| event_kind_i | input | 2 | Event code (R2) |
| osc_mode_i | input | 2 | Clock source code (R2) |
| pwrt_en_i | input | 1 | Power-up timer enable |
| release_o | output | 1 | High once all required waits are done |

## Verification
The bench runs all 32 combinations of event, clock source and timer enable. A reference model predicts the exact release cycle for each, and the bench compares it with the design every clock. This catches a design that chains a wait where none belongs, or leaves one out. The zero-wait cases (power-up in mode 2 or 3 with the timer off, and clock switch in mode 2 or 3) are checked on the very next cycle. A design with an off-by-one stage hand-off, or one that idles a cycle per skipped wait, would release late there. Brown-out with the timer disabled is checked so that a design which ties the brown-out wait to the enable would release early. Events that arrive mid-chain check the restart: a design that kept its old countdown would release at the stale time.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    EV_POWER_UP   = 2'd0,
    EV_BROWN_OUT  = 2'd1,
    EV_WAKE       = 2'd2,
    EV_CLK_SWITCH = 2'd3
  } event_e;

  typedef enum logic [1:0] {
    OSC_XTAL_PLL = 2'd0,
    OSC_XTAL     = 2'd1,
    OSC_EXT_CLK  = 2'd2,
    OSC_EXT_RC   = 2'd3
  } osc_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PWRT = 3'd1,
    PH_REC  = 3'd2,
    PH_OST  = 3'd3,
    PH_PLL  = 3'd4,
    PH_REL  = 3'd5
  } phase_e;

  typedef struct packed {
    logic pwrt;
    logic rec;
    logic ost;
    logic pll;
  } need_t;

  // Fixed chain order: (PWRT | REC) -> OST -> PLL -> REL; absent stages are skipped.
  function automatic phase_e pick_next(phase_e cur, need_t n);
    phase_e res;
    res = PH_REL;
    if (cur == PH_IDLE && n.pwrt)
      res = PH_PWRT;
    else if (cur == PH_IDLE && n.rec)
      res = PH_REC;
    else if ((cur == PH_IDLE || cur == PH_PWRT || cur == PH_REC) && n.ost)
      res = PH_OST;
    else if (cur != PH_PLL && cur != PH_REL && n.pll)
      res = PH_PLL;
    return res;
  endfunction

endpackage

// File: rtl/sdseq_plan.sv
module sdseq_plan
  import sdseq_pkg::*;
(
  input  logic [1:0] event_kind_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output need_t      need_o
);

  logic crystal, use_pll;

  assign crystal = (osc_e'(osc_mode_i) == OSC_XTAL_PLL) || (osc_e'(osc_mode_i) == OSC_XTAL);
  assign use_pll = (osc_e'(osc_mode_i) == OSC_XTAL_PLL);

  always_comb begin
    need_o = '0;
    case (event_e'(event_kind_i))
      EV_POWER_UP: begin
        need_o.pwrt = pwrt_en_i;
        need_o.ost  = crystal;
        need_o.pll  = use_pll;
      end
      EV_BROWN_OUT: begin
        need_o.pwrt = 1'b1;
        need_o.ost  = crystal;
        need_o.pll  = use_pll;
      end
      EV_WAKE: begin
        need_o.rec  = !crystal;
        need_o.ost  = crystal;
        need_o.pll  = use_pll;
      end
      default: begin
        need_o.ost  = crystal;
        need_o.pll  = use_pll;
      end
    endcase
  end

endmodule

// File: rtl/sdseq_timer.sv
module sdseq_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r2_timer_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

  a_r2_timer_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
  import sdseq_pkg::*;
#(
  parameter int PWRT_TICKS = 300,
  parameter int REC_TICKS  = 3,
  parameter int OST_TICKS  = 1024,
  parameter int PLL_TICKS  = 200,
  parameter int CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_valid_i,
  input  need_t            need_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             release_o
);

  phase_e phase_q, phase_d;
  need_t  need_q, need_d;
  logic   waiting;

  assign waiting = (phase_q == PH_PWRT) || (phase_q == PH_REC) ||
                   (phase_q == PH_OST)  || (phase_q == PH_PLL);

  always_comb begin
    phase_d = phase_q;
    need_d  = need_q;
    load_o  = 1'b0;
    if (event_valid_i) begin
      need_d  = need_i;
      phase_d = pick_next(PH_IDLE, need_i);
      load_o  = 1'b1;
    end else if (waiting && done_i) begin
      phase_d = pick_next(phase_q, need_q);
      load_o  = 1'b1;
    end
  end

  // Stage lasts N cycles: load N-1, hand off when the count is zero.
  always_comb begin
    case (phase_d)
      PH_PWRT: load_val_o = CNT_W'(PWRT_TICKS - 1);
      PH_REC:  load_val_o = CNT_W'(REC_TICKS - 1);
      PH_OST:  load_val_o = CNT_W'(OST_TICKS - 1);
      PH_PLL:  load_val_o = CNT_W'(PLL_TICKS - 1);
      default: load_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      need_q  <= '0;
    end else begin
      phase_q <= phase_d;
      need_q  <= need_d;
    end
  end

  assign release_o = (phase_q == PH_REL);

  a_r5_pll_stage_needs_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PLL) |-> need_q.pll);

  a_r4_pwrt_stage_needs_pwrt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PWRT) |-> need_q.pwrt);

  a_r1_idle_only_before_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> (phase_q != PH_IDLE));

  a_r7_restart_leaves_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_valid_i && need_i != '0) |=> (phase_q != PH_REL && phase_q != PH_IDLE));

endmodule

// File: rtl/start_delay_seq.sv
module start_delay_seq
  import sdseq_pkg::*;
#(
  parameter int PWRT_TICKS = 300,
  parameter int REC_TICKS  = 3,
  parameter int OST_TICKS  = 1024,
  parameter int PLL_TICKS  = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       event_valid_i,
  input  logic [1:0] event_kind_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output logic       release_o
);

  localparam int MAX_A  = (PWRT_TICKS > REC_TICKS) ? PWRT_TICKS : REC_TICKS;
  localparam int MAX_B  = (OST_TICKS > PLL_TICKS) ? OST_TICKS : PLL_TICKS;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  need_t            need;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;

  sdseq_plan u_plan (
    .event_kind_i (event_kind_i),
    .osc_mode_i   (osc_mode_i),
    .pwrt_en_i    (pwrt_en_i),
    .need_o       (need)
  );

  sdseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sdseq_fsm #(
    .PWRT_TICKS (PWRT_TICKS),
    .REC_TICKS  (REC_TICKS),
    .OST_TICKS  (OST_TICKS),
    .PLL_TICKS  (PLL_TICKS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .event_valid_i (event_valid_i),
    .need_i        (need),
    .done_i        (done),
    .load_o        (load),
    .load_val_o    (load_val),
    .release_o     (release_o)
  );

  a_r8_release_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o && !event_valid_i) |=> release_o);

  a_r3_empty_chain_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_valid_i && need == '0) |=> release_o);

  a_r2_event_drops_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_valid_i && need != '0) |=> !release_o);

  a_r6_switch_never_pwrt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_kind_i == 2'd3) |-> (!need.pwrt && !need.rec));

endmodule

// File: tb/sim_start_delay_seq.sv
module sim_start_delay_seq;

  localparam int PW  = 40;
  localparam int REC = 3;
  localparam int OST = 64;
  localparam int PLL = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev = 1'b0;
  logic [1:0] kind = '0;
  logic [1:0] mode = '0;
  logic       en = 1'b0;
  logic       rel;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  finished = 1'b0;
  string tag = "R1";

  // reference model state
  bit exp_rel = 1'b0;
  bit active = 1'b0;
  int remain = 0;

  always #10 clk = ~clk;

  start_delay_seq #(
    .PWRT_TICKS(PW), .REC_TICKS(REC), .OST_TICKS(OST), .PLL_TICKS(PLL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .event_valid_i(ev), .event_kind_i(kind),
    .osc_mode_i(mode), .pwrt_en_i(en), .release_o(rel)
  );

  function automatic int wait_len(int k, int m, bit e);
    int t;
    bit xtal;
    t = 0;
    xtal = (m < 2);
    if (k == 0 && e) t += PW;            // R3
    if (k == 1) t += PW;                 // R4
    if (k == 2 && !xtal) t += REC;       // R5
    if (xtal) t += OST;                  // R3 R4 R5 R6
    if (m == 0) t += PLL;
    return t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rel = 1'b0; active = 1'b0; remain = 0;
    end else if (ev) begin
      remain = wait_len(int'(kind), int'(mode), en);
      active = (remain != 0);
      exp_rel = (remain == 0);
    end else if (active) begin
      remain--;
      if (remain == 0) begin
        active = 1'b0;
        exp_rel = 1'b1;
      end
    end
  end

  task automatic check(string t, bit act, bit expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: release_o=%0b expected %0b at cycle %0d", t, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) check(tag, rel, exp_rel);
  end

  task automatic summary();
    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run not finished, actual cycle %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic fire(int k, int m, bit e);
    @(negedge clk);
    ev = 1'b1; kind = 2'(k); mode = 2'(m); en = e;
    @(negedge clk);
    ev = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1 check("R1 in reset", rel, 1'b0);
    idle(3);
    check("R1 in reset", rel, 1'b0);
    rst_n = 1'b1;
    tag = "R1";
    idle(10);

    // full sweep: every event, clock source and enable
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          case (k)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
          endcase
          fire(k, m, e[0]);
          // sample the cycle after the accepting edge: zero-wait chains are already high
          check({tag, " R2 first cycle"}, rel, (wait_len(k, m, e[0]) == 0));
          idle(wait_len(k, m, e[0]) + 4);
          tag = "R8";
          check("R8 held high", rel, 1'b1);
        end
      end
    end

    // restart mid-chain with a zero-wait event
    tag = "R7";
    fire(0, 0, 1'b1);
    idle(50);
    check("R7 mid-chain low", rel, 1'b0);
    fire(3, 2, 1'b0);
    check("R7 restart to zero wait", rel, 1'b1);
    idle(5);

    // restart mid-chain with a longer chain
    fire(1, 1, 1'b0);
    idle(PW + 10);
    fire(0, 0, 1'b1);
    idle(PW + OST);
    check("R7 stale timing ignored", rel, 1'b0);
    idle(PLL + 4);
    check("R7 new chain done", rel, 1'b1);

    // back-to-back events
    fire(2, 3, 1'b0);
    fire(2, 1, 1'b0);
    idle(OST + 3);
    check("R7 back-to-back", rel, 1'b1);

    tag = "R8";
    idle(20);
    summary();
  end

endmodule